// File: doc/BRIEF.md
# Instruction Prefetch Queue Controller

This block sits between a CPU core and a simple internal-bus read port. It keeps a small circular code buffer of bytes that the core draws its instruction stream from, and a fetch counter that holds the address of the next byte to read. The counter steps forward by one each time the bus accepts a read. It is overwritten with the core's program counter only when the core takes a branch or jump. A branch also throws away every queued byte.

Refills are gated by an instruction-request input and a CPU-run input. No read is started, and the counter cannot move, unless both are high. This keeps the counter locked to the core's program counter through a standby entry. That includes the case where a wake-up interrupt cancels the standby while the core is still halted, and the stop request drops before the core restarts.

The block also answers a bus-stop handshake. A bus-control-enable input freezes everything while it is low. A three-state machine drives fetching and the handshake:
- IDLE: no read outstanding.
- FETCH: a read is offered on the bus.
- GRANT: the bus is stopped and the grant is high.

The transitions are:
- start (IDLE to FETCH): request and run are high, the stop request is low, and the buffer has room or a branch empties it.
- refill (FETCH to FETCH): a read was accepted, the request is still up, and room remains after it.
- retire (FETCH to IDLE): a read was accepted and the buffer is then full, the request dropped, or a branch arrived with the request low.
- park (IDLE or FETCH to GRANT): the stop request is high and no read is left waiting.
- release (GRANT to IDLE): the stop request is low.

Top module: `prefetch_queue_ctrl`

## Requirements
- R1: After reset, `q_level` is 0, `stop_gnt` is 0, `rd_req` is 0, and `rd_addr` equals the RESET_ADDR parameter (default 0).
- R2: The buffer holds at most QDEPTH bytes (default 4) and hands them out first in, first out, in the order they were fetched. No read is offered while it is full (`q_level` = 4).
- R3: `rd_addr` is the fetch counter. It increases by exactly one for each cycle in which `rd_req` and `rd_ack` are both high and no branch is taken, and the byte on `rd_data` in that cycle is queued.
- R4: `rd_req` is high only in the FETCH state, and only when `ins_req`, `cpu_run` and `bus_en` are all high. While `ins_req` is low, the counter holds.
- R5: While `cpu_run` is low, `ins_valid` is 0, no read is offered, and the counter and `q_level` hold. This applies also after the stop request drops while the core is still halted.
- R6: A branch (`br_load` high while `bus_en` is high) loads `br_pc` into the counter and empties the buffer in the same clock. The next cycle shows `q_level` 0 and `rd_addr` equal to `br_pc`. An acknowledge in the branch cycle is discarded.
- R7: `stop_gnt` rises in the cycle after `stop_req` is sampled high with no read outstanding. If a read is being offered, it stays up until `rd_ack`, and `stop_gnt` rises in the cycle after that. No read is offered while `stop_gnt` is high.
- R8: When `stop_req` is sampled low during GRANT, `stop_gnt` falls in the next cycle, and fetching restarts from the held counter once request and run are high.
- R9: While `bus_en` is low, the following hold unchanged: `rd_req` is 0, `ins_valid` is 0, and the state, counter, `q_level` and `stop_gnt` keep their values. `rd_ack`, `br_load`, `ins_take` and `stop_req` have no effect.
- R10: `ins_valid` is high exactly when `bus_en`, `cpu_run` and `ins_take` are high, `q_level` is non-zero and no branch is present. `ins_data` is then the oldest byte, which is removed at the clock edge. A fill and a removal in the same clock leave `q_level` unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Bus-control enable; low freezes the block |
| cpu_run | input | 1 | High while the core executes |
| ins_req | input | 1 | Core permits refetch and counter advance |
| ins_take | input | 1 | Core removes the oldest queued byte |
| br_load | input | 1 | Branch: load counter, flush buffer |
| br_pc | input | AW | Branch target program counter |
| stop_req | input | 1 | Bus-stop request |
| stop_gnt | output | 1 | Bus-stop grant |
| rd_req | output | 1 | Read offered on the internal bus |
| rd_addr | output | AW | Fetch counter, read address |
| rd_ack | input | 1 | Read accepted this cycle |
| rd_data | input | DW | Read byte, valid with `rd_ack` |
| ins_valid | output | 1 | Oldest byte is taken this cycle |
| ins_data | output | DW | Oldest queued byte |
| q_level | output | $clog2(QDEPTH+1) | Number of queued bytes |

## Verification
The key collision is a branch arriving in the same clock as an accepted read. The read must be discarded and the counter must take the branch target rather than step. The bench provokes it by driving `br_load` with `rd_ack` high during FETCH, and then checks that `q_level` is 0 and `rd_addr` equals the target. The second collision is a stop request that lands while a read is waiting for its acknowledge. The bench holds `rd_ack` low for several cycles under `stop_req`, and requires the grant to stay low until one cycle after the acknowledge. A behavioural reference model, compared every cycle across a long random run, also judges a fill and a removal in the same clock.

// File: rtl/pfq_pkg.sv
package pfq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FETCH = 2'd1,
        ST_GRANT = 2'd2
    } fetch_state_t;
endpackage

// File: rtl/pfq_addr_ctr.sv
module pfq_addr_ctr #(
    parameter int              AW         = 16,
    parameter logic [AW-1:0]   RESET_ADDR = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          step,
    output logic [AW-1:0] ctr
);
    // A branch load always wins over a step in the same clock.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctr <= RESET_ADDR;
        end else if (load) begin
            ctr <= load_val;
        end else if (step) begin
            ctr <= ctr + AW'(1);
        end
    end
endmodule

// File: rtl/pfq_code_buf.sv
module pfq_code_buf #(
    parameter int DEPTH = 4,
    parameter int DW    = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         flush,
    input  logic                         push,
    input  logic [DW-1:0]                push_data,
    input  logic                         pop,
    output logic [DW-1:0]                head_data,
    output logic [$clog2(DEPTH+1)-1:0]   level
);
    localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNTW = $clog2(DEPTH + 1);

    logic [DW-1:0]   slot [DEPTH];
    logic [PTRW-1:0] head;
    logic [PTRW-1:0] wr_ptr;

    // DEPTH is a power of two, so the tail wraps by truncation.
    assign wr_ptr    = head + PTRW'(level);
    assign head_data = slot[head];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot[g] <= '0;
            end else if (push && !flush && (wr_ptr == PTRW'(g))) begin
                slot[g] <= push_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head  <= '0;
            level <= '0;
        end else if (flush) begin
            head  <= '0;
            level <= '0;
        end else begin
            head  <= head + PTRW'(pop);
            level <= level + CNTW'(push) - CNTW'(pop);
        end
    end

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        level <= CNTW'(DEPTH));
    p_no_push_full_r2: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (level < CNTW'(DEPTH)));
    p_no_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (level != '0));
endmodule

// File: rtl/pfq_fetch_fsm.sv
module pfq_fetch_fsm
    import pfq_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       bus_en,
    input  logic                       eff_req,
    input  logic                       stop_req,
    input  logic                       branch,
    input  logic                       rd_ack,
    input  logic                       pop,
    input  logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       rd_req,
    output logic                       push,
    output logic                       stop_gnt
);
    localparam int CNTW = $clog2(DEPTH + 1);

    fetch_state_t st, st_nx;
    logic [CNTW:0] lvl_after;
    logic          has_room;

    assign lvl_after = {1'b0, level} + (CNTW+1)'(1) - (CNTW+1)'(pop);
    assign has_room  = level < CNTW'(DEPTH);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st <= ST_IDLE;
        end else begin
            st <= st_nx;
        end
    end

    always_comb begin
        st_nx = st;
        if (bus_en) begin
            unique case (st)
                ST_IDLE: begin
                    if (stop_req) begin
                        st_nx = ST_GRANT;
                    end else if (eff_req && (branch || has_room)) begin
                        st_nx = ST_FETCH;
                    end
                end
                ST_FETCH: begin
                    if (branch) begin
                        st_nx = stop_req ? ST_GRANT : (eff_req ? ST_FETCH : ST_IDLE);
                    end else if (!eff_req) begin
                        st_nx = stop_req ? ST_GRANT : ST_IDLE;
                    end else if (rd_ack) begin
                        if (stop_req) begin
                            st_nx = ST_GRANT;
                        end else if (lvl_after < (CNTW+1)'(DEPTH)) begin
                            st_nx = ST_FETCH;
                        end else begin
                            st_nx = ST_IDLE;
                        end
                    end
                end
                ST_GRANT: begin
                    if (!stop_req) begin
                        st_nx = ST_IDLE;
                    end
                end
                default: st_nx = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        rd_req   = (st == ST_FETCH) && eff_req && bus_en;
        push     = rd_req && rd_ack && !branch;
        stop_gnt = (st == ST_GRANT);
    end

    p_grant_after_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_gnt) |-> $past(stop_req));
    p_grant_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_gnt && !stop_req && bus_en) |=> !stop_gnt);
    p_hold_read_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_ack && !branch && stop_req) |=> !stop_gnt);
endmodule

// File: rtl/prefetch_queue_ctrl.sv
module prefetch_queue_ctrl #(
    parameter int            AW         = 16,
    parameter int            DW         = 8,
    parameter int            QDEPTH     = 4,
    parameter logic [AW-1:0] RESET_ADDR = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          bus_en,
    input  logic                          cpu_run,
    input  logic                          ins_req,
    input  logic                          ins_take,
    input  logic                          br_load,
    input  logic [AW-1:0]                 br_pc,
    input  logic                          stop_req,
    output logic                          stop_gnt,
    output logic                          rd_req,
    output logic [AW-1:0]                 rd_addr,
    input  logic                          rd_ack,
    input  logic [DW-1:0]                 rd_data,
    output logic                          ins_valid,
    output logic [DW-1:0]                 ins_data,
    output logic [$clog2(QDEPTH+1)-1:0]   q_level
);
    logic eff_req;
    logic branch;
    logic push;
    logic pop;

    // Request only counts while the core is actually running.
    assign eff_req   = ins_req && cpu_run;
    assign branch    = br_load && bus_en;
    assign pop       = bus_en && cpu_run && ins_take && (q_level != '0) && !br_load;
    assign ins_valid = pop;

    pfq_fetch_fsm #(.DEPTH(QDEPTH)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_en   (bus_en),
        .eff_req  (eff_req),
        .stop_req (stop_req),
        .branch   (branch),
        .rd_ack   (rd_ack),
        .pop      (pop),
        .level    (q_level),
        .rd_req   (rd_req),
        .push     (push),
        .stop_gnt (stop_gnt)
    );

    pfq_addr_ctr #(.AW(AW), .RESET_ADDR(RESET_ADDR)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (branch),
        .load_val (br_pc),
        .step     (push),
        .ctr      (rd_addr)
    );

    pfq_code_buf #(.DEPTH(QDEPTH), .DW(DW)) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (branch),
        .push      (push),
        .push_data (rd_data),
        .pop       (pop),
        .head_data (ins_data),
        .level     (q_level)
    );

    p_ctr_hold_halt_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cpu_run && !br_load) |=> $stable(rd_addr));
    p_ctr_hold_noreq_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_req && !br_load) |=> $stable(rd_addr));
    p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_en |=> ($stable(q_level) && $stable(rd_addr) && $stable(stop_gnt)));
    p_branch_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (br_load && bus_en) |=> ((q_level == '0) && (rd_addr == $past(br_pc))));
    p_no_read_granted_r7: assert property (@(posedge clk) disable iff (!rst_n)
        stop_gnt |-> !rd_req);
endmodule

// File: tb/prefetch_queue_ctrl_tb.sv
`timescale 1ns/1ps
module prefetch_queue_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_en = 1'b1, cpu_run = 1'b1, ins_req = 1'b0, ins_take = 1'b0;
    logic        br_load = 1'b0, stop_req = 1'b0, rd_ack = 1'b0;
    logic [15:0] br_pc = '0;
    logic        stop_gnt, rd_req, ins_valid;
    logic [15:0] rd_addr;
    logic [7:0]  rd_data, ins_data;
    logic [2:0]  q_level;

    always #2 clk = ~clk;

    function automatic logic [7:0] mdat(input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ 8'h3C;
    endfunction
    assign rd_data = mdat(rd_addr);

    prefetch_queue_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .cpu_run(cpu_run),
        .ins_req(ins_req), .ins_take(ins_take), .br_load(br_load), .br_pc(br_pc),
        .stop_req(stop_req), .stop_gnt(stop_gnt), .rd_req(rd_req), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_data(rd_data), .ins_valid(ins_valid), .ins_data(ins_data),
        .q_level(q_level)
    );

    int n_chk = 0;
    int n_err = 0;

    bit          t_be = 1, t_cr = 1, t_rq = 0, t_tk = 0, t_bl = 0, t_sr = 0, t_ak = 0;
    logic [15:0] t_bp = '0;

    int          m_st = 0;
    logic [15:0] m_ctr = '0;
    logic [7:0]  m_q[$];

    task automatic chk_eq(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        bit br, eff, rdq, psh, pp;
        int lvl, nx;
        @(negedge clk);
        bus_en = t_be; cpu_run = t_cr; ins_req = t_rq; ins_take = t_tk;
        br_load = t_bl; br_pc = t_bp; stop_req = t_sr; rd_ack = t_ak;
        #1;
        br  = t_bl && t_be;
        eff = t_rq && t_cr;
        rdq = (m_st == 1) && eff && t_be;
        psh = rdq && t_ak && !br;
        pp  = t_be && t_cr && t_tk && (m_q.size() > 0) && !br;
        chk_eq("R4 rd_req", rd_req, rdq);
        chk_eq("R3 rd_addr", rd_addr, m_ctr);
        chk_eq("R7 stop_gnt", stop_gnt, m_st == 2);
        chk_eq("R2 q_level", q_level, m_q.size());
        chk_eq("R10 ins_valid", ins_valid, pp);
        if (pp) chk_eq("R2 ins_data", ins_data, m_q[0]);
        @(posedge clk);
        if (t_be) begin
            lvl = m_q.size();
            nx  = m_st;
            if (m_st == 0) begin
                if (t_sr) nx = 2;
                else if (eff && (br || lvl < 4)) nx = 1;
            end else if (m_st == 1) begin
                if (br) nx = t_sr ? 2 : (eff ? 1 : 0);
                else if (!eff) nx = t_sr ? 2 : 0;
                else if (t_ak) nx = t_sr ? 2 : (((lvl + 1 - (pp ? 1 : 0)) < 4) ? 1 : 0);
            end else begin
                if (!t_sr) nx = 0;
            end
            if (br) begin
                m_q.delete();
                m_ctr = t_bp;
            end else begin
                if (pp) void'(m_q.pop_front());
                if (psh) begin
                    m_q.push_back(mdat(m_ctr));
                    m_ctr = m_ctr + 16'd1;
                end
            end
            m_st = nx;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog R7 actual=hung expected=done");
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin : stim
        logic [15:0] a_sv;
        logic [2:0]  l_sv;
        bit          g_sv;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        #1;
        // R1 reset state
        chk_eq("R1 q_level", q_level, 0);
        chk_eq("R1 stop_gnt", stop_gnt, 0);
        chk_eq("R1 rd_req", rd_req, 0);
        chk_eq("R1 rd_addr", rd_addr, 16'h0000);

        // R2/R3 fill until full
        t_rq = 1; t_ak = 1; t_tk = 0;
        run(8);
        #1;
        chk_eq("R2 full level", q_level, 4);
        chk_eq("R3 counter after fill", rd_addr, 4);

        // R10/R4 drain in order with request low
        t_rq = 0; t_tk = 1;
        run(6);
        #1;
        chk_eq("R10 drained", q_level, 0);
        chk_eq("R4 counter held", rd_addr, 4);

        // wait states and concurrent fill/take
        t_rq = 1;
        for (int i = 0; i < 12; i++) begin
            t_tk = i[0]; t_ak = (i % 3 == 0);
            cyc();
        end

        // R7/R8 stop from idle
        t_rq = 0; t_tk = 1; t_ak = 0;
        run(6);
        t_tk = 0; t_sr = 1;
        cyc(); #1;
        chk_eq("R7 grant from idle", stop_gnt, 1);
        t_sr = 0;
        cyc(); #1;
        chk_eq("R8 grant drop", stop_gnt, 0);

        // R7 stop while a read waits for its acknowledge
        t_rq = 1; t_ak = 0;
        cyc();
        t_sr = 1;
        cyc(); #1;
        chk_eq("R7 grant held off", stop_gnt, 0);
        cyc(); #1;
        chk_eq("R7 grant held off 2", stop_gnt, 0);
        t_ak = 1;
        cyc(); #1;
        chk_eq("R7 grant after ack", stop_gnt, 1);
        chk_eq("R3 byte queued", q_level, 1);

        // R5 standby cancelled while core is halted
        t_ak = 0; t_cr = 0;
        run(2);
        a_sv = rd_addr;
        t_sr = 0; t_rq = 1; t_ak = 1;
        cyc(); #1;
        chk_eq("R8 grant falls core halted", stop_gnt, 0);
        run(5); #1;
        chk_eq("R5 counter held halted", rd_addr, a_sv);
        chk_eq("R5 level held halted", q_level, 1);
        t_cr = 1;
        run(3); #1;
        chk_eq("R8 fetch resumes", rd_addr, a_sv + 16'd2);

        // R6 branch colliding with an accepted read
        t_tk = 1;
        run(2);
        t_bl = 1; t_bp = 16'h2000;
        cyc(); #1;
        chk_eq("R6 flush", q_level, 0);
        chk_eq("R6 counter load", rd_addr, 16'h2000);
        t_bl = 0; t_tk = 0;

        // R9 freeze while bus control disabled
        run(3);
        #1;
        a_sv = rd_addr; l_sv = q_level; g_sv = stop_gnt;
        t_be = 0; t_tk = 1; t_bl = 1; t_bp = 16'h7777; t_sr = 1;
        run(4); #1;
        chk_eq("R9 counter frozen", rd_addr, a_sv);
        chk_eq("R9 level frozen", q_level, l_sv);
        chk_eq("R9 grant frozen", stop_gnt, g_sv);
        t_be = 1; t_bl = 0; t_sr = 0; t_tk = 0;

        // mixed traffic against the model
        for (int i = 0; i < 3000; i++) begin
            t_be = ($urandom_range(7) != 0);
            t_cr = ($urandom_range(7) != 0);
            t_rq = ($urandom_range(3) != 0);
            t_tk = $urandom_range(1);
            t_bl = ($urandom_range(31) == 0);
            t_bp = 16'($urandom);
            if ($urandom_range(15) == 0) t_sr = !t_sr;
            t_ak = $urandom_range(1);
            cyc();
        end

        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule